// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host-side master for an eight-channel successive-approximation ADC with a serial interface. A client sends a request over a valid/ready handshake. The request holds a 3-bit channel number and a justification flag. The controller then pulls chip select low and waits a programmable number of system clocks. It generates sixteen serial clock periods. Over the first four of them it sends the command, and over all sixteen it collects the result word from the converter. After the frame it waits for the converter's busy line to pulse high and then return low.

The converter always returns the result of the conversion started by the previous frame. Because of this, the controller keeps the channel and format bit of the last accepted request. It uses them to strip the six padding zeros from the correct end of the word and to tag the returned 10-bit value. The converter's content before the first conversion is undefined, so the first result after reset is marked invalid. If the busy handshake does not finish within a bounded number of cycles, the controller raises a timeout pulse. It then returns to idle, and the next result is marked invalid.

The control path is one state machine with five states:
- `ST_IDLE` accepts a request and goes to `ST_SETUP`.
- `ST_SETUP` holds chip select low for `CS_SETUP` clocks and then goes to `ST_SHIFT`.
- `ST_SHIFT` runs the serial clock and goes to `ST_ARM` on the sixteenth falling edge.
- `ST_ARM` waits for synchronized busy to go high and then goes to `ST_DRAIN`.
- `ST_DRAIN` waits for synchronized busy to go low, emits the response and returns to `ST_IDLE`.
- From either `ST_ARM` or `ST_DRAIN`, the timeout limit sends the machine back to `ST_IDLE`.

Top module: `adc_host_ctrl`

## Requirements
- R1: Chip select is low for at least `CS_SETUP` system clocks before the first rising serial clock edge of a frame, and the serial clock is low whenever chip select is high.
- R2: Data out to the converter carries channel bit 0, channel bit 1, channel bit 2 and then the justification flag (1 = right-justified), one per serial clock, and changes only on falling edges, so it is stable at every rising edge.
- R3: Each frame contains exactly 16 rising serial clock edges between the falling and the rising edge of chip select.
- R4: With the stored flag at 0 (left-justified), the result is the first ten received bits, MSB first, and the last six are dropped.
- R5: With the stored flag at 1 (right-justified), the first six received bits are dropped and the result is the last ten received bits, MSB first.
- R6: Each response carries the channel number of the request accepted before the current one.
- R7: The response of the first transaction after reset has `rsp_ok` low; later responses after a completed handshake have it high.
- R8: The response pulse appears exactly three clock edges after the external busy line falls (two-flop synchronizer plus one register), and no request is accepted before that.
- R9: If the busy handshake does not complete within `BUSY_TMO` clocks of chip select rising, `timeout_err` pulses for one cycle at exactly that edge, no response is issued, and the next response has `rsp_ok` low.
- R10: In reset, chip select is high, the serial clock is low, `req_ready` is high, and `rsp_valid` and `timeout_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_chan | input | 3 | Channel to convert |
| req_rjust | input | 1 | 1 = right-justified frame for this conversion |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 10 | Conversion result of the previous request |
| rsp_chan | output | 3 | Channel tag of the previous request |
| rsp_ok | output | 1 | Result is trustworthy |
| timeout_err | output | 1 | One-cycle pulse on busy handshake timeout |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_di | output | 1 | Command bit to the converter |
| adc_do | input | 1 | Result bit from the converter |
| adc_busy | input | 1 | Converter busy status (asynchronous) |

## Verification
The response strobe is due three clock edges after the busy line falls, and the timeout pulse is due `BUSY_TMO` edges after chip select rises. The bench's reference model keeps a countdown for each of these events and compares both outputs against it on every falling system clock edge. Command bits and the number of serial edges are checked in the bench's converter model at the rising edge of chip select. The setup interval is counted in falling system clock edges up to the first high serial clock sample. Response contents are compared in the cycle the strobe is seen, against values derived from the request history.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    localparam int CH_W      = 3;
    localparam int RES_W     = 10;
    localparam int FRAME_LEN = 16;
    localparam int CMD_W     = CH_W + 1;
    localparam int PAD_W     = FRAME_LEN - RES_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_ARM,
        ST_DRAIN
    } ctl_state_t;
endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == CW'(HALF - 1));
    assign rise_evt = run && wrap && !sclk;
    assign fall_evt = run && wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= !sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int SCLK_HALF   = 4,
    parameter int CS_SETUP    = 6,
    parameter int BUSY_TMO    = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CH_W-1:0]  req_chan,
    input  logic             req_rjust,
    output logic             rsp_valid,
    output logic [RES_W-1:0] rsp_data,
    output logic [CH_W-1:0]  rsp_chan,
    output logic             rsp_ok,
    output logic             timeout_err,
    output logic             adc_sclk,
    output logic             adc_cs_n,
    output logic             adc_di,
    input  logic             adc_do,
    input  logic             adc_busy
);
    localparam int SW   = $clog2(CS_SETUP + 1);
    localparam int TW   = $clog2(BUSY_TMO + 1);
    localparam int FC_W = $clog2(FRAME_LEN + 1);

    ctl_state_t state, nstate;

    logic [SW-1:0]        setup_cnt;
    logic [TW-1:0]        tmo_cnt;
    logic [FC_W-1:0]      fall_cnt;
    logic [CMD_W-1:0]     cmd_q;
    logic [FRAME_LEN-1:0] rx_sr;
    logic [CH_W-1:0]      prev_chan;
    logic                 prev_rj;
    logic                 prev_ok;
    logic                 busy_s;
    logic                 sclk_rise, sclk_fall;
    logic                 accept, setup_done, frame_done, tmo_hit;

    adc_bit_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_busy),
        .q     (busy_s)
    );

    adc_sclk_div #(.HALF(SCLK_HALF)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_SHIFT),
        .sclk     (adc_sclk),
        .rise_evt (sclk_rise),
        .fall_evt (sclk_fall)
    );

    assign accept     = req_valid && (state == ST_IDLE);
    assign setup_done = (setup_cnt == SW'(CS_SETUP - 1));
    assign frame_done = sclk_fall && (fall_cnt == FC_W'(FRAME_LEN - 1));
    assign tmo_hit    = (tmo_cnt == TW'(BUSY_TMO - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (accept)      nstate = ST_SETUP;
            ST_SETUP: if (setup_done)  nstate = ST_SHIFT;
            ST_SHIFT: if (frame_done)  nstate = ST_ARM;
            ST_ARM:   if (tmo_hit)     nstate = ST_IDLE;
                      else if (busy_s) nstate = ST_DRAIN;
            ST_DRAIN: if (tmo_hit || !busy_s) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // pin-level outputs decoded from state
    assign req_ready = (state == ST_IDLE);
    assign adc_cs_n  = !((state == ST_SETUP) || (state == ST_SHIFT));
    assign adc_di    = !adc_cs_n && (fall_cnt < FC_W'(CMD_W))
                       && cmd_q[fall_cnt[$clog2(CMD_W)-1:0]];

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_cnt   <= '0;
            tmo_cnt     <= '0;
            fall_cnt    <= '0;
            cmd_q       <= '0;
            rx_sr       <= '0;
            prev_chan   <= '0;
            prev_rj     <= 1'b0;
            prev_ok     <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
            rsp_chan    <= '0;
            rsp_ok      <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            rsp_valid   <= 1'b0;
            timeout_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd_q     <= {req_rjust, req_chan};
                        setup_cnt <= '0;
                        fall_cnt  <= '0;
                    end
                end
                ST_SETUP: setup_cnt <= setup_cnt + 1'b1;
                ST_SHIFT: begin
                    tmo_cnt <= '0;
                    if (sclk_rise) rx_sr    <= {rx_sr[FRAME_LEN-2:0], adc_do};
                    if (sclk_fall) fall_cnt <= fall_cnt + 1'b1;
                end
                ST_ARM, ST_DRAIN: begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                    if (tmo_hit) begin
                        timeout_err <= 1'b1;
                        prev_chan   <= cmd_q[CH_W-1:0];
                        prev_rj     <= cmd_q[CMD_W-1];
                        prev_ok     <= 1'b0;
                    end else if ((state == ST_DRAIN) && !busy_s) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= prev_rj ? rx_sr[RES_W-1:0]
                                             : rx_sr[FRAME_LEN-1 -: RES_W];
                        rsp_chan  <= prev_chan;
                        rsp_ok    <= prev_ok;
                        prev_chan <= cmd_q[CH_W-1:0];
                        prev_rj   <= cmd_q[CMD_W-1];
                        prev_ok   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_chan,
    input logic       req_rjust,
    input logic       rsp_valid,
    input logic [9:0] rsp_data,
    input logic [2:0] rsp_chan,
    input logic       rsp_ok,
    input logic       timeout_err,
    input logic       adc_sclk,
    input logic       adc_cs_n,
    input logic       adc_di,
    input logic       adc_do,
    input logic       adc_busy
);
    logic [4:0] rise_cnt;
    logic       sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= adc_sclk;
            if (adc_cs_n)                rise_cnt <= '0;
            else if (adc_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r1_sclk_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    a_r2_di_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && adc_sclk && !$past(adc_sclk)) |-> $stable(adc_di));

    a_r3_sixteen_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (rise_cnt == 5'd16));

    a_r8_ready_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> adc_cs_n);

    a_r8_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_timeout_excludes_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !rsp_valid);
endmodule

bind adc_host_ctrl adc_host_ctrl_chk u_chk (.*);

// File: tb/sim_adc_host_ctrl.sv
module sim_adc_host_ctrl;
    localparam int HALF     = 4;
    localparam int SETUP    = 6;
    localparam int TMO      = 4000;
    localparam int BUSY_LEN = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_ready, req_rjust = 1'b0;
    logic [2:0] req_chan = '0;
    logic       rsp_valid, rsp_ok, timeout_err;
    logic [9:0] rsp_data;
    logic [2:0] rsp_chan;
    logic       adc_sclk, adc_cs_n, adc_di;
    logic       adc_do = 1'b0, adc_busy = 1'b0;

    always #10 clk = ~clk;

    adc_host_ctrl #(.SCLK_HALF(HALF), .CS_SETUP(SETUP), .BUSY_TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_rjust(req_rjust), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_chan(rsp_chan), .rsp_ok(rsp_ok),
        .timeout_err(timeout_err), .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n),
        .adc_di(adc_di), .adc_do(adc_do), .adc_busy(adc_busy)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] conv(input int ch, input int n);
        return 10'((ch * 113 + n * 71 + 517) % 1024);
    endfunction

    // converter model
    bit         dev_en = 0;
    bit         no_busy = 0;
    logic [15:0] dev_frame;
    int         dev_idx = 0, dev_rises = 0, dev_n = 0;
    logic [3:0] dev_cmd = '0;
    logic [9:0] dev_val = 10'h2A5;
    logic       dev_rj = 1'b0;
    int         cur_ch = 0, cur_rj = 0;

    always @(negedge adc_cs_n) if (dev_en) begin
        dev_frame = dev_rj ? {6'b0, dev_val} : {dev_val, 6'b0};
        dev_idx   = 0;
        dev_rises = 0;
        adc_do    = dev_frame[15];
    end

    always @(posedge adc_sclk) if (dev_en && !adc_cs_n) begin
        if (dev_rises < 4) dev_cmd[dev_rises] = adc_di;
        dev_rises++;
    end

    always @(negedge adc_sclk) if (dev_en && !adc_cs_n) begin
        dev_idx++;
        adc_do = (dev_idx < 16) ? dev_frame[15 - dev_idx] : 1'b0;
    end

    always @(posedge adc_cs_n) if (dev_en) begin
        chk(dev_rises == 16, "R3 rising edges per frame", dev_rises, 16);
        if (dev_rises == 16) begin
            chk(dev_cmd == {cur_rj[0], cur_ch[2:0]}, "R2 command bits",
                dev_cmd, {cur_rj[0], cur_ch[2:0]});
            dev_val = conv(int'(dev_cmd[2:0]), dev_n);
            dev_rj  = dev_cmd[3];
            dev_n++;
            dev_rises = 0;
            repeat (4) @(negedge clk);
            if (!no_busy) begin
                adc_busy <= 1'b1;
                repeat (BUSY_LEN) @(negedge clk);
                adc_busy <= 1'b0;
            end
        end
    end

    // reference model, compared every clock
    int  rec_ch[16], rec_rj[16];
    int  n_tx = 0, bf = 0, tc = -1, pre_cnt = 0, tmo_seen = 0;
    bit  prev_b = 0, prev_cs = 1, seen_rise = 0, m_ok = 0, after_tmo = 0;

    always @(negedge clk) if (dev_en) begin
        if (prev_b && !adc_busy) bf = 1;
        else if (bf > 0) bf++;
        chk(rsp_valid == (bf == 3), "R8 response strobe timing", rsp_valid, bf == 3);
        if (bf >= 3) bf = 0;
        prev_b = adc_busy;

        if (!prev_cs && adc_cs_n) tc = 0;
        else if (tc >= 0) tc++;
        chk(timeout_err == (no_busy && tc == TMO), "R9 timeout timing",
            timeout_err, no_busy && tc == TMO);
        prev_cs = adc_cs_n;

        if (timeout_err) begin
            m_ok = 0;
            after_tmo = 1;
            tmo_seen++;
            tc = -1;
        end

        if (rsp_valid) begin
            automatic int k = n_tx - 1;
            if (k == 0)
                chk(rsp_ok == 1'b0, "R7 first result invalid", rsp_ok, 0);
            else if (after_tmo)
                chk(rsp_ok == 1'b0, "R9 result after timeout invalid", rsp_ok, 0);
            else
                chk(rsp_ok == m_ok, "R7 validity flag", rsp_ok, m_ok);
            if (k > 0)
                chk(rsp_chan == 3'(rec_ch[k-1]), "R6 channel tag", rsp_chan, rec_ch[k-1]);
            if (m_ok && k > 0) begin
                if (rec_rj[k-1] != 0)
                    chk(rsp_data == conv(rec_ch[k-1], k-1), "R5 right-justified result",
                        rsp_data, conv(rec_ch[k-1], k-1));
                else
                    chk(rsp_data == conv(rec_ch[k-1], k-1), "R4 left-justified result",
                        rsp_data, conv(rec_ch[k-1], k-1));
            end
            m_ok = 1;
            after_tmo = 0;
        end

        if (adc_cs_n) begin
            pre_cnt = 0;
            seen_rise = 0;
        end else if (!seen_rise) begin
            if (adc_sclk) begin
                seen_rise = 1;
                chk(pre_cnt >= SETUP, "R1 chip select setup", pre_cnt, SETUP);
            end else begin
                pre_cnt++;
            end
        end
    end

    task automatic send(input int ch, input int rj);
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = 3'(ch);
        req_rjust = rj[0];
        while (!req_ready) @(negedge clk);
        rec_ch[n_tx] = ch;
        rec_rj[n_tx] = rj;
        cur_ch = ch;
        cur_rj = rj;
        n_tx++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_sim;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_sim();
    end

    initial begin
        int chs[11] = '{3, 5, 7, 0, 6, 1, 2, 4, 5, 7, 3};
        int rjs[11] = '{0, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0};
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1,    "R10 reset chip select", adc_cs_n, 1);
        chk(adc_sclk == 1'b0,    "R10 reset serial clock", adc_sclk, 0);
        chk(req_ready == 1'b1,   "R10 reset ready", req_ready, 1);
        chk(rsp_valid == 1'b0,   "R10 reset response", rsp_valid, 0);
        chk(timeout_err == 1'b0, "R10 reset timeout", timeout_err, 0);
        rst_n  = 1'b1;
        dev_en = 1;
        for (int i = 0; i < 11; i++) begin
            if (i == 7) no_busy = 1;
            send(chs[i], rjs[i]);
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            chk(adc_busy == 1'b0, "R8 idle only after busy low", adc_busy, 0);
            if (i == 7) begin
                @(negedge clk);
                no_busy = 0;
                chk(tmo_seen == 1, "R9 timeout raised", tmo_seen, 1);
            end
        end
        repeat (5) @(negedge clk);
        finish_sim();
    end
endmodule